// File: doc/BRIEF.md
# Crate Slave Port with Look-At-Me Logic

This block is the slave side of a module on a crate dataway. When the station-select line is high and the command strobe arrives, it decodes the function and subaddress codes. It then runs one of a small command set: streaming access to a 24-bit shared memory through a 15-bit pointer that steps after every access, loading or reading that pointer, reading three look-at-me (LAM) registers, setting or clearing mask bits selectively, and testing the LAM line. Each command returns the crate's X (command accepted) and Q (response) bits.

The LAM status register captures the status lines of the module's sources on every clock. The mask register is changed only through selective set and clear commands. The request register is the bitwise AND of status and mask, and the LAM output is high whenever any request bit is set. The shared memory is modelled inside the block by a small array that decodes only the low pointer bits. The full pointer still leaves on the memory address port for a full-size array. All responses are registered. They appear in the cycle after the strobe and hold until the next strobe.

Top module: `crate_slave_port`

## Requirements
- R1: After reset the pointer and mask are zero, X, Q and the read data are zero, LAM is low, and the memory enable is low.
- R2: Function 0 at subaddress 0 returns the memory word at the pointer with X=1 and Q=1, then advances the pointer by one.
- R3: Function 16 at subaddress 0 stores the write data at the pointer with X=1 and Q=1, then advances the pointer by one.
- R4: Function 1 at subaddress 0 returns the pointer in read data bits 14..0. Function 17 at subaddress 0 loads the pointer from write data bits 14..0. Both answer X=1 and Q=0.
- R5: Advancing the pointer from 0x7FFF gives 0.
- R6: Function 1 at subaddresses 12, 13 and 14 returns the status, mask and request registers respectively in the low read data bits, with upper bits zero, X=1 and Q=0.
- R7: Function 19 at subaddress 13 sets every mask bit whose write data bit is 1. Function 23 at subaddress 13 clears every mask bit whose write data bit is 1. Other mask bits are kept. Both answer X=1 and Q=0.
- R8: The request register equals status AND mask, and the LAM output is 1 exactly when some request bit is 1. Status follows the status inputs with one clock of delay.
- R9: Function 8 at subaddress 15 answers X=1 and Q equal to the LAM output at the strobe.
- R10: A strobe with station-select low, or with any other function/subaddress pair, answers X=0, Q=0 and read data 0, and changes neither pointer, mask nor memory.
- R11: X, Q and read data change only in the cycle after a strobe and hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stn_sel | input | 1 | Station select for this module |
| func | input | 5 | Function code |
| subaddr | input | 4 | Subaddress code |
| strobe | input | 1 | One-cycle command strobe |
| wdata | input | 24 | Write data |
| status_in | input | 13 | LAM status source lines |
| rdata | output | 24 | Read data |
| resp_q | output | 1 | Q response |
| resp_x | output | 1 | X response |
| lam | output | 1 | Look-at-me request line |
| mem_addr | output | 15 | Shared memory address (the pointer) |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Memory access is a write |

## Verification
Assertions check on every cycle that the pointer steps by one after each memory command and wraps at the top, and that selective set and clear writes leave the chosen mask bits at the chosen value while other cycles leave the mask untouched. They also check that rejected strobes answer with X and Q low and keep the pointer, that the LAM test answers with the LAM state, and that responses hold between strobes. Only the bench scenarios show that data written at one pointer value reads back at the same value, that register reads return the right contents, and that the request and LAM outputs follow the status inputs through changing masks.

// File: rtl/crate_slv_pkg.sv
package crate_slv_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MEM_RD,
        OP_MEM_WR,
        OP_PTR_RD,
        OP_PTR_WR,
        OP_STAT_RD,
        OP_MASK_RD,
        OP_REQ_RD,
        OP_MASK_SET,
        OP_MASK_CLR,
        OP_LAM_TEST
    } op_e;

    typedef struct packed {
        logic x;
        logic q;
    } resp_t;

    function automatic op_e decode_op(logic [4:0] f, logic [3:0] a);
        op_e op;
        case ({f, a})
            {5'd0,  4'd0}:  op = OP_MEM_RD;
            {5'd16, 4'd0}:  op = OP_MEM_WR;
            {5'd1,  4'd0}:  op = OP_PTR_RD;
            {5'd17, 4'd0}:  op = OP_PTR_WR;
            {5'd1,  4'd12}: op = OP_STAT_RD;
            {5'd1,  4'd13}: op = OP_MASK_RD;
            {5'd1,  4'd14}: op = OP_REQ_RD;
            {5'd19, 4'd13}: op = OP_MASK_SET;
            {5'd23, 4'd13}: op = OP_MASK_CLR;
            {5'd8,  4'd15}: op = OP_LAM_TEST;
            default:        op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic resp_t op_resp(op_e op, logic lam_now);
        resp_t r;
        case (op)
            OP_NONE:               r = '{x: 1'b0, q: 1'b0};
            OP_MEM_RD, OP_MEM_WR:  r = '{x: 1'b1, q: 1'b1};
            OP_LAM_TEST:           r = '{x: 1'b1, q: lam_now};
            default:               r = '{x: 1'b1, q: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slv_ptr_unit.sv
module slv_ptr_unit #(
    parameter int PTR_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr == {PTR_W{1'b1}}) |=> (ptr == '0));

endmodule

// File: rtl/slv_lam_regs.sv
module slv_lam_regs #(
    parameter int LAM_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAM_W-1:0] status_in,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [LAM_W-1:0] bits,
    output logic [LAM_W-1:0] status_q,
    output logic [LAM_W-1:0] mask_q,
    output logic [LAM_W-1:0] req,
    output logic             lam
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_in;
            if (set_en)      mask_q <= mask_q | bits;
            else if (clr_en) mask_q <= mask_q & ~bits;
        end
    end

    assign req = status_q & mask_q;
    assign lam = |req;

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((mask_q & $past(bits)) == $past(bits)));

    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((mask_q & $past(bits)) == '0));

    // R10
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/slv_mem_model.sv
module slv_mem_model #(
    parameter int AW = 10,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) cells[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata <= '0;
        else if (en && !we)  rdata <= cells[addr];
    end

endmodule

// File: rtl/crate_slave_port.sv
module crate_slave_port
    import crate_slv_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int PTR_W    = 15,
    parameter int LAM_W    = 13,
    parameter int MODEL_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stn_sel,
    input  logic [4:0]        func,
    input  logic [3:0]        subaddr,
    input  logic              strobe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LAM_W-1:0]  status_in,
    output logic [DATA_W-1:0] rdata,
    output logic              resp_q,
    output logic              resp_x,
    output logic              lam,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              mem_en,
    output logic              mem_we
);

    localparam int PTR_PAD = DATA_W - PTR_W;
    localparam int LAM_PAD = DATA_W - LAM_W;

    op_e               op;
    resp_t             resp_now;
    logic [PTR_W-1:0]  ptr;
    logic [LAM_W-1:0]  status_q, mask_q, req;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] rd_hold;
    logic [DATA_W-1:0] rd_next;
    logic              sel_mem;

    always_comb begin
        op = OP_NONE;
        if (strobe && stn_sel) op = decode_op(func, subaddr);
    end

    assign mem_en   = (op == OP_MEM_RD) || (op == OP_MEM_WR);
    assign mem_we   = (op == OP_MEM_WR);
    assign mem_addr = ptr;
    assign resp_now = op_resp(op, lam);

    slv_ptr_unit #(.PTR_W(PTR_W)) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (op == OP_PTR_WR),
        .load_val (wdata[PTR_W-1:0]),
        .step     (mem_en),
        .ptr      (ptr)
    );

    slv_lam_regs #(.LAM_W(LAM_W)) i_lam (
        .clk       (clk),
        .rst       (rst),
        .status_in (status_in),
        .set_en    (op == OP_MASK_SET),
        .clr_en    (op == OP_MASK_CLR),
        .bits      (wdata[LAM_W-1:0]),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .req       (req),
        .lam       (lam)
    );

    slv_mem_model #(.AW(MODEL_AW), .DW(DATA_W)) i_mem (
        .clk   (clk),
        .rst   (rst),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (ptr[MODEL_AW-1:0]),
        .wdata (wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        case (op)
            OP_PTR_RD:  rd_next = {{PTR_PAD{1'b0}}, ptr};
            OP_STAT_RD: rd_next = {{LAM_PAD{1'b0}}, status_q};
            OP_MASK_RD: rd_next = {{LAM_PAD{1'b0}}, mask_q};
            OP_REQ_RD:  rd_next = {{LAM_PAD{1'b0}}, req};
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_x  <= 1'b0;
            resp_q  <= 1'b0;
            rd_hold <= '0;
            sel_mem <= 1'b0;
        end else if (strobe) begin
            resp_x  <= resp_now.x;
            resp_q  <= resp_now.q;
            rd_hold <= rd_next;
            sel_mem <= (op == OP_MEM_RD);
        end
    end

    assign rdata = sel_mem ? mem_rdata : rd_hold;

    // R10
    bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && op == OP_NONE) |=> (!resp_x && !resp_q && $stable(ptr)));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R9
    lam_test_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LAM_TEST) |=> (resp_x && resp_q == $past(lam)));

    // R11
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(resp_x) && $stable(resp_q) && $stable(rdata)));

endmodule

// File: tb/test_crate_slave_port.sv
`timescale 1ns/1ps
module test_crate_slave_port;

    localparam int DW  = 24;
    localparam int PW  = 15;
    localparam int LW  = 13;
    localparam int MAW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          stn_sel;
    logic [4:0]    func;
    logic [3:0]    subaddr;
    logic          strobe;
    logic [DW-1:0] wdata;
    logic [LW-1:0] status_in;
    logic [DW-1:0] rdata;
    logic          resp_q, resp_x, lam;
    logic [PW-1:0] mem_addr;
    logic          mem_en, mem_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PW-1:0] m_ptr;
    logic [LW-1:0] m_mask, m_stat;
    logic [DW-1:0] m_mem [1 << MAW];

    always #2 clk = ~clk;

    crate_slave_port i_crate_slave_port (
        .clk(clk), .rst(rst), .stn_sel(stn_sel), .func(func), .subaddr(subaddr),
        .strobe(strobe), .wdata(wdata), .status_in(status_in), .rdata(rdata),
        .resp_q(resp_q), .resp_x(resp_x), .lam(lam), .mem_addr(mem_addr),
        .mem_en(mem_en), .mem_we(mem_we)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 none,1 mem rd,2 mem wr,3 ptr rd,4 ptr wr,5 stat,6 mask,7 req,8 set,9 clr,10 test
    function automatic int kind(logic sel, logic [4:0] f, logic [3:0] a);
        if (!sel) return 0;
        if (f == 0  && a == 0)  return 1;
        if (f == 16 && a == 0)  return 2;
        if (f == 1  && a == 0)  return 3;
        if (f == 17 && a == 0)  return 4;
        if (f == 1  && a == 12) return 5;
        if (f == 1  && a == 13) return 6;
        if (f == 1  && a == 14) return 7;
        if (f == 19 && a == 13) return 8;
        if (f == 23 && a == 13) return 9;
        if (f == 8  && a == 15) return 10;
        return 0;
    endfunction

    function automatic logic m_lam();
        return |(m_stat & m_mask);
    endfunction

    task automatic cmd(logic sel, logic [4:0] f, logic [3:0] a, logic [DW-1:0] wd);
        int k;
        logic [DW-1:0] e_rd;
        logic e_x, e_q;
        string tag;
        k = kind(sel, f, a);
        e_rd = '0;
        e_x = (k != 0);
        e_q = (k == 1) || (k == 2) || (k == 10 && m_lam());
        case (k)
            1: e_rd = m_mem[m_ptr[MAW-1:0]];
            3: e_rd = DW'(m_ptr);
            5: e_rd = DW'(m_stat);
            6: e_rd = DW'(m_mask);
            7: e_rd = DW'(m_stat & m_mask);
            default: ;
        endcase
        case (k)
            0: tag = "R10"; 1: tag = "R2"; 2: tag = "R3"; 3, 4: tag = "R4";
            5, 6, 7: tag = "R6"; 8, 9: tag = "R7"; default: tag = "R9";
        endcase
        stn_sel = sel; func = f; subaddr = a; wdata = wd; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk({tag, " x"}, resp_x, e_x);
        chk({tag, " q"}, resp_q, e_q);
        chk({tag, " rdata"}, rdata, e_rd);
        case (k)
            1: m_ptr = m_ptr + 1'b1;
            2: begin m_mem[m_ptr[MAW-1:0]] = wd; m_ptr = m_ptr + 1'b1; end
            4: m_ptr = wd[PW-1:0];
            8: m_mask = m_mask | wd[LW-1:0];
            9: m_mask = m_mask & ~wd[LW-1:0];
            default: ;
        endcase
        chk("R8 lam", lam, m_lam());
    endtask

    task automatic set_status(logic [LW-1:0] s);
        status_in = s;
        @(negedge clk);
        m_stat = s;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; stn_sel = 0; func = 0; subaddr = 0; strobe = 0; wdata = 0; status_in = 0;
        m_ptr = 0; m_mask = 0; m_stat = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 x", resp_x, 0);
        chk("R1 q", resp_q, 0);
        chk("R1 rdata", rdata, 0);
        chk("R1 lam", lam, 0);
        chk("R1 mem_en", mem_en, 0);
        chk("R1 ptr", mem_addr, 0);

        // R3 fill the modelled memory
        for (int i = 0; i < (1 << MAW); i++) cmd(1, 16, 0, DW'($urandom));
        // R2 stream back part of it
        cmd(1, 17, 0, 0);
        for (int i = 0; i < 40; i++) cmd(1, 0, 0, 0);

        // R5 wrap
        cmd(1, 17, 0, 24'h7FFF);
        cmd(1, 16, 0, 24'hABCDEF);
        cmd(1, 1, 0, 0);
        chk("R5 ptr after wrap", mem_addr, 0);
        cmd(1, 17, 0, 24'hFFFFFF);
        cmd(1, 0, 0, 0);
        cmd(1, 1, 0, 0);

        // R7 R8 R9 directed LAM sequence
        set_status('1);
        cmd(1, 8, 15, 0);
        cmd(1, 19, 13, 24'h5);
        cmd(1, 1, 14, 0);
        cmd(1, 8, 15, 0);
        cmd(1, 19, 13, 24'h100);
        cmd(1, 23, 13, 24'h5);
        cmd(1, 1, 13, 0);
        set_status(13'h0FF);
        cmd(1, 8, 15, 0);
        cmd(1, 1, 12, 0);
        cmd(1, 23, 13, 24'hFFFFFF);

        // R10 unselected write and unsupported pair leave state alone
        cmd(0, 16, 0, 24'h123456);
        cmd(1, 19, 13, 24'h3);
        cmd(0, 23, 13, 24'h3);
        cmd(1, 2, 0, 24'h3);
        cmd(1, 1, 13, 0);
        cmd(1, 1, 0, 0);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int c;
            c = int'($urandom % 14);
            if ($urandom % 10 == 0) set_status(LW'($urandom));
            case (c)
                0:  cmd(1, 0, 0, 0);
                1:  cmd(1, 16, 0, DW'($urandom));
                2:  cmd(1, 1, 0, 0);
                3:  cmd(1, 17, 0, DW'($urandom));
                4:  cmd(1, 1, 12, 0);
                5:  cmd(1, 1, 13, 0);
                6:  cmd(1, 1, 14, 0);
                7:  cmd(1, 19, 13, DW'($urandom));
                8:  cmd(1, 23, 13, DW'($urandom));
                9:  cmd(1, 8, 15, 0);
                10: cmd(0, 5'($urandom), 4'($urandom), DW'($urandom));
                default: cmd(1, 5'($urandom), 4'($urandom), DW'($urandom));
            endcase
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule